// File: doc/BRIEF.md
# Noise Source Word Provider with Repetition Health Monitor

This block is the digital front end for one physical noise source. Each cycle it may receive one raw bit from the source digitizer, together with a strobe that marks the bit as a fresh sample. The bits can pass through an optional pairwise debiasing stage. Bits that survive are shifted into a 32-bit packing register, and each full word goes into a small output queue. A downstream mixer or conditioner sees only the read side of that queue, and every provider of this kind presents the same read side. The block does not control the analog source. It only drives a registered enable that software may use to turn the source's bias on or off.

A repetition monitor runs on every raw sample, before any debiasing. If one bit value repeats too long, the source is treated as stuck or dead and a sticky alarm is raised. While the alarm stands, completed words are thrown away rather than queued. Packing continues, so word alignment is kept. A clear pulse removes the alarm and restarts the run count.

Top module: `entropy_feeder`

## Requirements
- R1: After reset, healthFail is 0, fifoEmpty is 1, rdValid is 0 and biasEnable is 0.
- R2: biasEnable takes the value of cfgSourceOn one clock edge later.
- R3: With whitenOn low, every sample taken with rawValid high is packed. The first sample of a word ends up at rdData bit 31 and the 32nd sample at bit 0.
- R4: With whitenOn high, samples are taken in non-overlapping pairs counted from reset or from enabling. Pair (0 then 1) packs a 0, pair (1 then 0) packs a 1, and pairs 00 and 11 pack nothing.
- R5: Lowering whitenOn discards a half-collected pair. After whitenOn is raised again, the next sample is the first of a new pair.
- R6: healthFail rises on the 65th consecutive raw sample with the same value and not on the 64th. The run count uses raw samples whether or not whitening is on.
- R7: healthFail stays high until an errClear pulse, which lowers it and restarts the run count from zero.
- R8: A word that completes while healthFail is high, or on the sample that raises it, is not queued. Packing still advances during that time.
- R9: A read pulse on a non-empty queue gives rdValid high with the oldest word on rdData one cycle later. A read pulse on an empty queue leaves rdValid low.
- R10: The queue holds 16 words. A word that completes while the queue is full is dropped, and the stored words are kept in their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSourceOn | input | 1 | Requested state of the source bias enable |
| biasEnable | output | 1 | Registered enable toward the source bias control |
| rawBit | input | 1 | Raw sample bit from the digitizer |
| rawValid | input | 1 | rawBit holds a new sample this cycle |
| whitenOn | input | 1 | Select the pairwise debiasing stage |
| errClear | input | 1 | Clear the health alarm and restart the run count |
| healthFail | output | 1 | Sticky stuck-source alarm |
| rdEn | input | 1 | Read pulse toward the output queue |
| rdData | output | 32 | Word read from the queue, valid with rdValid |
| rdValid | output | 1 | rdData holds a word read on the previous cycle |
| fifoEmpty | output | 1 | Queue holds no words |

## Verification
The case that is hardest to reach from the ports is a dropped word under an active alarm. To see that dropping did not upset alignment, the alarm must first be tripped part-way through the packing sequence. The stimulus sends exactly 65 ones so the alarm trips one bit into the third word, and 31 more bits to complete a word that must vanish. After a clear it sends a known word, and that word must come out intact. Overflow is driven by 17 distinct words in a row, and the pair-phase reset is driven by leaving a stray half pair before whitening is toggled.

// File: rtl/entropy_feeder_pkg.sv
package entropy_feeder_pkg;

  localparam int WORD_W = 32;

  // Strobes passed from the control side to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // one accepted bit is presented this cycle
    logic shiftBit;  // value of that bit
    logic dropWord;  // a word completing this cycle must not be queued
  } packStrobe_t;

endpackage

// File: rtl/entropy_feeder_fifo.sv
module entropy_feeder_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             empty
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             full, wrDo, rdDo;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign wrDo  = wrEn && !full;
  assign rdDo  = rdEn && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrDo) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdDo;
      if (rdDo) begin
        rdData <= mem[rdPtr];
        rdPtr  <= bump(rdPtr);
      end
      if (wrDo) wrPtr <= bump(wrPtr);
      case ({wrDo, rdDo})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10: a push into a full queue without a read leaves the level alone
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && full && !rdEn |=> $stable(count));

  // R10: level never exceeds the depth
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R9: reading an empty queue produces no valid word
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && empty |=> !rdValid);

endmodule

// File: rtl/entropy_feeder_ctrl.sv
module entropy_feeder_ctrl
  import entropy_feeder_pkg::*;
#(
  parameter int REP_CUTOFF = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgSourceOn,
  input  logic        rawBit,
  input  logic        rawValid,
  input  logic        whitenOn,
  input  logic        errClear,
  input  logic        fifoEmpty,
  output logic        biasEnable,
  output logic        healthFail,
  output packStrobe_t strobe
);

  localparam int RUN_W = $clog2(REP_CUTOFF + 2);
  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(REP_CUTOFF + 1);
  localparam logic [RUN_W-1:0] RUN_CUT = RUN_W'(REP_CUTOFF);

  logic [RUN_W-1:0] runLen, runNext;
  logic             lastBit;
  logic             failQ;
  logic             sameRun, trip, sampleOk;
  logic             pairHalf, pairFirst;
  logic             biasQ;

  assign sampleOk = rawValid && !errClear;

  // Repetition monitor on raw samples
  always_comb begin
    sameRun = (runLen != '0) && (rawBit == lastBit);
    if (!sameRun)               runNext = RUN_W'(1);
    else if (runLen == RUN_CAP) runNext = runLen;
    else                        runNext = runLen + 1'b1;
    trip = sampleOk && sameRun && (runLen >= RUN_CUT);
  end

  // Optional pairwise debiasing
  always_comb begin
    strobe = '0;
    if (whitenOn) begin
      strobe.shiftEn  = sampleOk && pairHalf && (rawBit != pairFirst);
      strobe.shiftBit = pairFirst;
    end else begin
      strobe.shiftEn  = sampleOk;
      strobe.shiftBit = rawBit;
    end
    strobe.dropWord = failQ || trip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen    <= '0;
      lastBit   <= 1'b0;
      failQ     <= 1'b0;
      pairHalf  <= 1'b0;
      pairFirst <= 1'b0;
      biasQ     <= 1'b0;
    end else begin
      biasQ <= cfgSourceOn;
      if (errClear) begin
        failQ  <= 1'b0;
        runLen <= '0;
      end else if (rawValid) begin
        runLen  <= runNext;
        lastBit <= rawBit;
        if (trip) failQ <= 1'b1;
      end
      if (!whitenOn) begin
        pairHalf <= 1'b0;
      end else if (sampleOk) begin
        pairHalf <= !pairHalf;
        if (!pairHalf) pairFirst <= rawBit;
      end
    end
  end

  assign biasEnable = biasQ;
  assign healthFail = failQ;

  // R7: alarm holds until cleared
  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    healthFail && !errClear |=> healthFail);

  // R7: a clear always removes the alarm
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rstN)
    errClear |=> !healthFail);

  // R6: a sample that extends a run past the cutoff raises the alarm
  assert_trip_R6: assert property (@(posedge clk) disable iff (!rstN)
    rawValid && !errClear && (runLen == RUN_CUT) && (rawBit == lastBit) |=> healthFail);

  // R4: the first half of a pair never packs a bit
  assert_half_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    whitenOn && !pairHalf |-> !strobe.shiftEn);

  // R8: while words are being dropped an empty queue stays empty
  assert_drop_keeps_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    healthFail && !errClear && fifoEmpty |=> fifoEmpty);

endmodule

// File: rtl/entropy_feeder_dp.sv
module entropy_feeder_dp
  import entropy_feeder_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  packStrobe_t      strobe,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             fifoEmpty
);

  localparam int CW = $clog2(WIDTH);

  logic [WIDTH-1:0] shReg, wordData;
  logic [CW-1:0]    bitCnt;
  logic             wordDone, push;

  assign wordDone = strobe.shiftEn && (bitCnt == CW'(WIDTH - 1));
  assign wordData = {shReg[WIDTH-2:0], strobe.shiftBit};
  assign push     = wordDone && !strobe.dropWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      shReg  <= wordData;
      bitCnt <= wordDone ? '0 : bitCnt + 1'b1;
    end
  end

  entropy_feeder_fifo #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (push),
    .wrData  (wordData),
    .rdEn    (rdEn),
    .rdData  (rdData),
    .rdValid (rdValid),
    .empty   (fifoEmpty)
  );

  // R3: the bit counter only advances on presented bits
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(bitCnt));

endmodule

// File: rtl/entropy_feeder.sv
module entropy_feeder
  import entropy_feeder_pkg::*;
#(
  parameter int REP_CUTOFF = 64,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSourceOn,
  output logic              biasEnable,
  input  logic              rawBit,
  input  logic              rawValid,
  input  logic              whitenOn,
  input  logic              errClear,
  output logic              healthFail,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              fifoEmpty
);

  packStrobe_t strobe;

  entropy_feeder_ctrl #(
    .REP_CUTOFF (REP_CUTOFF)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgSourceOn (cfgSourceOn),
    .rawBit      (rawBit),
    .rawValid    (rawValid),
    .whitenOn    (whitenOn),
    .errClear    (errClear),
    .fifoEmpty   (fifoEmpty),
    .biasEnable  (biasEnable),
    .healthFail  (healthFail),
    .strobe      (strobe)
  );

  entropy_feeder_dp #(
    .WIDTH (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdEn      (rdEn),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .fifoEmpty (fifoEmpty)
  );

endmodule

// File: tb/sim_entropy_feeder.sv
module sim_entropy_feeder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSourceOn = 1'b0;
  logic        rawBit = 1'b0;
  logic        rawValid = 1'b0;
  logic        whitenOn = 1'b0;
  logic        errClear = 1'b0;
  logic        rdEn = 1'b0;
  logic        biasEnable, healthFail, rdValid, fifoEmpty;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  entropy_feeder u0 (
    .clk(clk), .rstN(rstN), .cfgSourceOn(cfgSourceOn), .biasEnable(biasEnable),
    .rawBit(rawBit), .rawValid(rawValid), .whitenOn(whitenOn), .errClear(errClear),
    .healthFail(healthFail), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .fifoEmpty(fifoEmpty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rawValid = 1'b0; whitenOn = 1'b0; errClear = 1'b0; rdEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    rawBit = b; rawValid = 1'b1;
    @(negedge clk);
    rawValid = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic sendPairs(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      sendBit(w[i]); sendBit(!w[i]);
      if (i % 4 == 0) begin sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); end
    end
  endtask

  task automatic readWord(output logic [31:0] d, output logic v);
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic pulseClear();
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 healthFail", {31'b0, healthFail}, 32'd0);
    check("R1 fifoEmpty", {31'b0, fifoEmpty}, 32'd1);
    check("R1 rdValid", {31'b0, rdValid}, 32'd0);
    check("R1 biasEnable", {31'b0, biasEnable}, 32'd0);
  endtask

  task automatic testBias();
    @(negedge clk); cfgSourceOn = 1'b1;
    @(negedge clk);
    check("R2 bias on", {31'b0, biasEnable}, 32'd1);
    cfgSourceOn = 1'b0;
    @(negedge clk);
    check("R2 bias off", {31'b0, biasEnable}, 32'd0);
  endtask

  task automatic testPackAndEmptyRead();
    logic [31:0] d; logic v;
    doReset();
    readWord(d, v);
    check("R9 empty read", {31'b0, v}, 32'd0);
    sendWord(32'hC0FF_EE15);
    check("R3 not empty", {31'b0, fifoEmpty}, 32'd0);
    readWord(d, v);
    check("R9 valid", {31'b0, v}, 32'd1);
    check("R3 word", d, 32'hC0FF_EE15);
  endtask

  task automatic testWhiten();
    logic [31:0] d; logic v;
    doReset();
    @(negedge clk); whitenOn = 1'b1;
    sendPairs(32'h9E37_79B9);
    readWord(d, v);
    check("R4 valid", {31'b0, v}, 32'd1);
    check("R4 word", d, 32'h9E37_79B9);
  endtask

  task automatic testPhaseReset();
    logic [31:0] d; logic v;
    doReset();
    @(negedge clk); whitenOn = 1'b1;
    sendBit(1'b1);
    @(negedge clk); whitenOn = 1'b0;
    @(negedge clk); whitenOn = 1'b1;
    sendPairs(32'h1357_9BDF);
    readWord(d, v);
    check("R5 valid", {31'b0, v}, 32'd1);
    check("R5 word", d, 32'h1357_9BDF);
  endtask

  task automatic testHealthAndDrop();
    logic [31:0] d; logic v;
    doReset();
    for (int i = 0; i < 64; i++) sendBit(1'b1);
    check("R6 no trip at 64", {31'b0, healthFail}, 32'd0);
    sendBit(1'b1);
    check("R6 trip at 65", {31'b0, healthFail}, 32'd1);
    for (int i = 0; i < 31; i++) sendBit(i[0]);
    repeat (5) @(negedge clk);
    check("R7 sticky", {31'b0, healthFail}, 32'd1);
    readWord(d, v);
    check("R8 first word", d, 32'hFFFF_FFFF);
    readWord(d, v);
    check("R8 second word", d, 32'hFFFF_FFFF);
    readWord(d, v);
    check("R8 dropped word absent", {31'b0, v}, 32'd0);
    pulseClear();
    check("R7 cleared", {31'b0, healthFail}, 32'd0);
    sendWord(32'hA5A5_5A5A);
    readWord(d, v);
    check("R8 alignment kept", d, 32'hA5A5_5A5A);
  endtask

  task automatic testWhitenRawCount();
    doReset();
    @(negedge clk); whitenOn = 1'b1;
    for (int i = 0; i < 65; i++) sendBit(1'b0);
    check("R6 raw count under whitening", {31'b0, healthFail}, 32'd1);
    check("R8 nothing queued", {31'b0, fifoEmpty}, 32'd1);
  endtask

  task automatic testRunRestart();
    doReset();
    for (int i = 0; i < 40; i++) sendBit(1'b1);
    pulseClear();
    for (int i = 0; i < 40; i++) sendBit(1'b1);
    check("R7 run restart", {31'b0, healthFail}, 32'd0);
  endtask

  task automatic testFull();
    logic [31:0] d; logic v;
    doReset();
    for (int i = 0; i < 17; i++) sendWord(32'h5A3C_9600 + i);
    for (int i = 0; i < 16; i++) begin
      readWord(d, v);
      check("R10 order", d, 32'h5A3C_9600 + i);
    end
    readWord(d, v);
    check("R10 overflow dropped", {31'b0, v}, 32'd0);
  endtask

  initial begin
    testReset();
    testBias();
    testPackAndEmptyRead();
    testWhiten();
    testPhaseReset();
    testHealthAndDrop();
    testWhitenRawCount();
    testRunRestart();
    testFull();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule